// File: doc/BRIEF.md
# Program Counter and Control-Transfer Unit

This block holds the byte-address program counter for a stream of 32-bit, word-aligned instructions. It decodes the control-transfer opcodes in the current instruction word and works out the next fetch address. Execution advances one instruction on each cycle where the step strobe is high. Before any instruction takes effect, the counter is first bumped by 4. Every relative target and every saved return address is computed from that bumped value.

The surrounding pipeline supplies three inputs: the instruction word, the value already read from the register named in the instruction's first register field, and the step strobe. In return the unit gives:

- the fetch address for the next instruction;
- a link-write request (enable, register index, value) that the register file applies;
- a one-cycle service-call request carrying its service number;
- a halted flag that stays set until reset.

Relative offsets count 4-byte words, so the counter can never leave word alignment.

Top module: `seq_branch_unit`

## Requirements
- R1: Synchronous active-high reset sets the fetch address to 0 and clears the halted flag.
- R2: A step whose opcode (bits [5:0]) is not a control transfer moves the fetch address to current+4. A cycle with step low leaves the fetch address unchanged.
- R3: Opcode 0x03 (relative jump) sets the fetch address to current+4 plus the sign-extended 26-bit field in bits [31:6], multiplied by 4.
- R4: Opcode 0x04 (jump and link) takes the same target as R3. In the same step it raises the link-write enable with index RA_IDX (default 1) and value current+4.
- R5: Opcodes 0x07, 0x08, 0x09 and 0x0a test the register value as a signed number for equal to zero, not zero, negative and positive, in that order. When the test holds, the fetch address becomes current+4 plus the sign-extended 21-bit field in bits [31:11] times 4. Otherwise it becomes current+4. Bits [10:6] name the tested register.
- R6: Opcode 0x05 (indirect jump) loads the fetch address from the register value with its low two bits cleared.
- R7: Opcode 0x06 (indirect jump and link) requests a link write of current+4 to RA_IDX and loads the fetch address as in R6.
- R8: Opcode 0x01 (halt) advances the fetch address to current+4 and sets the halted flag. From then until reset, steps change neither the fetch address nor the flag, and raise no link or service request.
- R9: Opcode 0x02 (service call) raises the service request during its step, with the service number taken from bits [31:6], and advances the fetch address by 4.
- R10: The fetch address is always a multiple of 4.
- R11: The link-write enable and the service request are high only in a cycle where step is high and the unit is not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Execute the current instruction this cycle |
| instr | input | 32 | Current instruction word |
| rs_val | input | XLEN | Value of the register named in bits [10:6] |
| fetch_addr | output | XLEN | Program counter, byte address of the instruction to fetch |
| link_we | output | 1 | Request to write the return address |
| link_idx | output | 5 | Destination register of the link write |
| link_val | output | XLEN | Return address (current+4) |
| sys_req | output | 1 | Service-call request |
| sys_num | output | 26 | Service number |
| halted | output | 1 | Execution has stopped |

## Verification
Two situations are the hardest to reach from the ports.

The first is the halted state, which is only observable through what stops happening afterwards. The stimulus therefore steps a halt instruction and then keeps stepping a link jump and a service call. It checks that the fetch address, link enable and service request all stay quiet, and that only reset recovers the unit.

The second is the set of sign corners of the conditional tests: the most negative value must not count as positive, and a negative branch offset must be able to land back on its own address. A chained vector table walks the counter through forward and backward jumps, taken and untaken tests, indirect targets with low bits set, and both link forms. Each expected address in the table is worked out from the requirements.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

    localparam int INSTR_W    = 32;
    localparam int OPC_W      = 6;
    localparam int RIDX_W     = 5;
    localparam int IMM_J_W    = 26;
    localparam int IMM_B_W    = 21;
    localparam int WORD_SHIFT = 2;

    localparam logic [OPC_W-1:0] OPC_HALT = 6'h01;
    localparam logic [OPC_W-1:0] OPC_SYS  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_JMP  = 6'h03;
    localparam logic [OPC_W-1:0] OPC_JAL  = 6'h04;
    localparam logic [OPC_W-1:0] OPC_JR   = 6'h05;
    localparam logic [OPC_W-1:0] OPC_JRL  = 6'h06;
    localparam logic [OPC_W-1:0] OPC_BEZ  = 6'h07;
    localparam logic [OPC_W-1:0] OPC_BNZ  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_BLZ  = 6'h09;
    localparam logic [OPC_W-1:0] OPC_BGZ  = 6'h0a;

    typedef enum logic [2:0] {
        K_SEQ,
        K_REL,
        K_COND,
        K_IND,
        K_HALT,
        K_SYS
    } xfer_kind_e;

    typedef enum logic [1:0] {
        C_EQZ,
        C_NEZ,
        C_LTZ,
        C_GTZ
    } zcond_e;

    typedef struct packed {
        xfer_kind_e           kind;
        zcond_e               cond;
        logic                 link;
        logic [IMM_J_W-1:0]   imm_j;
        logic [IMM_B_W-1:0]   imm_b;
    } xfer_dec_t;

    function automatic logic [OPC_W-1:0] opc_of(input logic [INSTR_W-1:0] w);
        return w[OPC_W-1:0];
    endfunction

endpackage

// File: rtl/sbu_decode.sv
module sbu_decode
    import sbu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output xfer_dec_t          dec
);

    logic [OPC_W-1:0] opc;

    assign opc = opc_of(instr);

    always_comb begin
        dec.kind  = K_SEQ;
        dec.cond  = C_EQZ;
        dec.link  = 1'b0;
        dec.imm_j = instr[INSTR_W-1 -: IMM_J_W];
        dec.imm_b = instr[INSTR_W-1 -: IMM_B_W];
        case (opc)
            OPC_HALT: dec.kind = K_HALT;
            OPC_SYS:  dec.kind = K_SYS;
            OPC_JMP:  dec.kind = K_REL;
            OPC_JAL: begin
                dec.kind = K_REL;
                dec.link = 1'b1;
            end
            OPC_JR:   dec.kind = K_IND;
            OPC_JRL: begin
                dec.kind = K_IND;
                dec.link = 1'b1;
            end
            OPC_BEZ: begin
                dec.kind = K_COND;
                dec.cond = C_EQZ;
            end
            OPC_BNZ: begin
                dec.kind = K_COND;
                dec.cond = C_NEZ;
            end
            OPC_BLZ: begin
                dec.kind = K_COND;
                dec.cond = C_LTZ;
            end
            OPC_BGZ: begin
                dec.kind = K_COND;
                dec.cond = C_GTZ;
            end
            default:  dec.kind = K_SEQ;
        endcase
    end

endmodule

// File: rtl/sbu_cond.sv
module sbu_cond
    import sbu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rs_val,
    input  zcond_e          cond,
    output logic            taken
);

    logic is_zero;
    logic is_neg;

    assign is_zero = (rs_val == '0);
    assign is_neg  = rs_val[XLEN-1];

    always_comb begin
        case (cond)
            C_EQZ:   taken = is_zero;
            C_NEZ:   taken = !is_zero;
            C_LTZ:   taken = is_neg;
            C_GTZ:   taken = !is_neg && !is_zero;
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/sbu_next.sv
module sbu_next
    import sbu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-1:0]    rs_val,
    input  xfer_kind_e         kind,
    input  logic               taken,
    input  logic [IMM_J_W-1:0] imm_j,
    input  logic [IMM_B_W-1:0] imm_b,
    output logic [XLEN-1:0]    pc_inc,
    output logic [XLEN-1:0]    next_pc
);

    localparam logic [XLEN-1:0] STEP_BYTES = XLEN'(1 << WORD_SHIFT);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'((1 << WORD_SHIFT) - 1);

    logic [XLEN-1:0] off_j;
    logic [XLEN-1:0] off_b;
    logic [XLEN-1:0] ind_tgt;

    assign pc_inc  = pc + STEP_BYTES;
    assign off_j   = XLEN'($signed(imm_j)) << WORD_SHIFT;
    assign off_b   = XLEN'($signed(imm_b)) << WORD_SHIFT;
    assign ind_tgt = rs_val & ALIGN_MASK;

    always_comb begin
        case (kind)
            K_REL:   next_pc = pc_inc + off_j;
            K_COND:  next_pc = taken ? (pc_inc + off_b) : pc_inc;
            K_IND:   next_pc = ind_tgt;
            default: next_pc = pc_inc;
        endcase
    end

endmodule

// File: rtl/seq_branch_unit.sv
module seq_branch_unit
    import sbu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int RA_IDX = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 step,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [XLEN-1:0]      rs_val,
    output logic [XLEN-1:0]      fetch_addr,
    output logic                 link_we,
    output logic [RIDX_W-1:0]    link_idx,
    output logic [XLEN-1:0]      link_val,
    output logic                 sys_req,
    output logic [IMM_J_W-1:0]   sys_num,
    output logic                 halted
);

    localparam logic [XLEN-1:0] STEP_BYTES = XLEN'(1 << WORD_SHIFT);

    xfer_dec_t       dec;
    logic            taken;
    logic            live;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_inc;
    logic [XLEN-1:0] next_pc;
    logic            halted_q;

    sbu_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    sbu_cond #(.XLEN(XLEN)) u_cond (
        .rs_val (rs_val),
        .cond   (dec.cond),
        .taken  (taken)
    );

    sbu_next #(.XLEN(XLEN)) u_next (
        .pc      (pc_q),
        .rs_val  (rs_val),
        .kind    (dec.kind),
        .taken   (taken),
        .imm_j   (dec.imm_j),
        .imm_b   (dec.imm_b),
        .pc_inc  (pc_inc),
        .next_pc (next_pc)
    );

    assign live = step && !halted_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            halted_q <= 1'b0;
        end else if (live) begin
            pc_q <= next_pc;
            if (dec.kind == K_HALT) begin
                halted_q <= 1'b1;
            end
        end
    end

    assign fetch_addr = pc_q;
    assign halted     = halted_q;
    assign link_we    = live && dec.link;
    assign link_idx   = RIDX_W'(RA_IDX);
    assign link_val   = pc_inc;
    assign sys_req    = live && (dec.kind == K_SYS);
    assign sys_num    = dec.imm_j;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetch_addr == '0 && !halted));

    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !halted && dec.kind == K_SEQ) |=> (fetch_addr == $past(fetch_addr) + STEP_BYTES));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(fetch_addr));

    assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(fetch_addr)));

    assert_word_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        fetch_addr[WORD_SHIFT-1:0] == '0);

    assert_req_gated_R11: assert property (@(posedge clk) disable iff (rst)
        (link_we || sys_req) |-> (step && !halted));

    assert_sys_no_link_R9: assert property (@(posedge clk) disable iff (rst)
        sys_req |-> !link_we);

endmodule

// File: tb/test_seq_branch_unit.sv
module test_seq_branch_unit;

    localparam int XLEN = 64;

    typedef struct packed {
        logic [31:0]     instr;
        logic [XLEN-1:0] rs;
        logic [XLEN-1:0] exp_pc;
        logic            exp_lwe;
        logic [XLEN-1:0] exp_lval;
    } vec_t;

    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] imm);
        return {imm, op};
    endfunction

    function automatic logic [31:0] enc_b(input logic [5:0] op, input logic [4:0] r,
                                          input logic [20:0] imm);
        return {imm, r, op};
    endfunction

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{enc_b(6'h15, 5'd3, 21'd9),       64'd0,                  64'd4,    1'b0, 64'd0},
        '{enc_j(6'h03, 26'd3),             64'd0,                  64'd20,   1'b0, 64'd0},
        '{enc_j(6'h03, 26'h3FFFFFE),       64'd0,                  64'd16,   1'b0, 64'd0},
        '{enc_b(6'h07, 5'd5, 21'd4),       64'd0,                  64'd36,   1'b0, 64'd0},
        '{enc_b(6'h07, 5'd5, 21'd4),       64'd7,                  64'd40,   1'b0, 64'd0},
        '{enc_b(6'h08, 5'd2, 21'd2),       64'd1,                  64'd52,   1'b0, 64'd0},
        '{enc_b(6'h08, 5'd2, 21'd2),       64'd0,                  64'd56,   1'b0, 64'd0},
        '{enc_b(6'h09, 5'd9, 21'd1),       64'hFFFF_FFFF_FFFF_FFFF,64'd64,   1'b0, 64'd0},
        '{enc_b(6'h09, 5'd9, 21'd1),       64'd0,                  64'd68,   1'b0, 64'd0},
        '{enc_b(6'h0a, 5'd4, 21'd3),       64'h8000_0000_0000_0000,64'd72,   1'b0, 64'd0},
        '{enc_b(6'h0a, 5'd4, 21'd3),       64'd1,                  64'd88,   1'b0, 64'd0},
        '{enc_j(6'h04, 26'd5),             64'd0,                  64'd112,  1'b1, 64'd92},
        '{enc_b(6'h05, 5'd6, 21'd0),       64'h1003,               64'd4096, 1'b0, 64'd0},
        '{enc_b(6'h06, 5'd6, 21'd0),       64'h200,                64'd512,  1'b1, 64'd4100},
        '{enc_j(6'h02, 26'h2A),            64'd0,                  64'd516,  1'b0, 64'd0},
        '{enc_b(6'h09, 5'd3, 21'h1FFFFF),  64'hFFFF_FFFF_FFFF_FFFB,64'd516,  1'b0, 64'd0},
        '{enc_b(6'h00, 5'd0, 21'd0),       64'd0,                  64'd520,  1'b0, 64'd0}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            step = 1'b0;
    logic [31:0]     instr = '0;
    logic [XLEN-1:0] rs_val = '0;
    logic [XLEN-1:0] fetch_addr;
    logic            link_we;
    logic [4:0]      link_idx;
    logic [XLEN-1:0] link_val;
    logic            sys_req;
    logic [25:0]     sys_num;
    logic            halted;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    logic            s_lwe;
    logic [4:0]      s_lidx;
    logic [XLEN-1:0] s_lval;
    logic            s_sys;
    logic [25:0]     s_snum;

    always #4 clk = ~clk;

    seq_branch_unit #(.XLEN(XLEN), .RA_IDX(1)) i_seq_branch_unit (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .instr      (instr),
        .rs_val     (rs_val),
        .fetch_addr (fetch_addr),
        .link_we    (link_we),
        .link_idx   (link_idx),
        .link_val   (link_val),
        .sys_req    (sys_req),
        .sys_num    (sys_num),
        .halted     (halted)
    );

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] op);
        case (op)
            6'h03:                      return "R3";
            6'h04:                      return "R4";
            6'h07, 6'h08, 6'h09, 6'h0a: return "R5";
            6'h05:                      return "R6";
            6'h06:                      return "R7";
            6'h02:                      return "R9";
            default:                    return "R2";
        endcase
    endfunction

    task automatic run_step(input logic [31:0] w, input logic [XLEN-1:0] r, input logic stb);
        @(negedge clk);
        instr  = w;
        rs_val = r;
        step   = stb;
        #2;
        s_lwe  = link_we;
        s_lidx = link_idx;
        s_lval = link_val;
        s_sys  = sys_req;
        s_snum = sys_num;
        @(negedge clk);
        step = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset fetch_addr", fetch_addr, 64'd0);
        chk("R1 reset halted", {63'd0, halted}, 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            string t;
            t = tag_of(VECS[i].instr[5:0]);
            run_step(VECS[i].instr, VECS[i].rs, 1'b1);
            chk({t, " next fetch_addr"}, fetch_addr, VECS[i].exp_pc);
            chk("R10 alignment", {62'd0, fetch_addr[1:0]}, 64'd0);
            chk({t, " link_we"}, {63'd0, s_lwe}, {63'd0, VECS[i].exp_lwe});
            if (VECS[i].exp_lwe) begin
                chk({t, " link_val"}, s_lval, VECS[i].exp_lval);
                chk({t, " link_idx"}, {59'd0, s_lidx}, 64'd1);
            end
            chk("R9 sys_req", {63'd0, s_sys}, {63'd0, (VECS[i].instr[5:0] == 6'h02)});
            if (VECS[i].instr[5:0] == 6'h02) begin
                chk("R9 sys_num", {38'd0, s_snum}, 64'h2A);
            end
        end

        // R2 / R11: step low holds the address and raises nothing
        run_step(enc_j(6'h04, 26'd7), 64'd0, 1'b0);
        chk("R2 idle hold", fetch_addr, 64'd520);
        chk("R11 idle link_we", {63'd0, s_lwe}, 64'd0);

        // R8: halt advances once then freezes
        run_step(enc_j(6'h01, 26'd0), 64'd0, 1'b1);
        chk("R8 halt fetch_addr", fetch_addr, 64'd524);
        chk("R8 halted set", {63'd0, halted}, 64'd1);
        run_step(enc_j(6'h04, 26'd9), 64'd0, 1'b1);
        chk("R8 halted ignores jump", fetch_addr, 64'd524);
        chk("R11 halted link_we", {63'd0, s_lwe}, 64'd0);
        run_step(enc_j(6'h02, 26'h11), 64'd0, 1'b1);
        chk("R11 halted sys_req", {63'd0, s_sys}, 64'd0);
        chk("R8 halted still", {63'd0, halted}, 64'd1);
        run_step(enc_b(6'h06, 5'd2, 21'd0), 64'h40, 1'b1);
        chk("R8 halted ignores indirect", fetch_addr, 64'd524);

        // R1: reset recovers
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 re-reset fetch_addr", fetch_addr, 64'd0);
        chk("R1 re-reset halted", {63'd0, halted}, 64'd0);
        run_step(enc_j(6'h03, 26'd1), 64'd0, 1'b1);
        chk("R3 after reset", fetch_addr, 64'd8);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule